// File: doc/BRIEF.md
# SCL Minimum-Width Pulse Filter

This block cleans a serial clock line before it reaches a downstream device. A controller can emit a short phantom high pulse on SCL, typically just after the downstream device stretches the clock. A device that ignores narrow pulses then counts one clock fewer than the controller does, and the bus falls out of step. The filter samples SCL with a local clock and passes a high pulse only once it has stayed high for a programmable number of sample cycles. Pulses that end earlier are removed whole and counted.

A qualified pulse reaches the output late by the synchroniser plus the qualification time. It ends two cycles after the input falls is seen. The threshold should sit well above the widest phantom pulse and well below a nominal high phase. At a 100 kHz bus with a 1.5 us threshold, the added delay still leaves the device's data response ahead of the controller's sampling point. After filtering, a byte plus its acknowledge shows exactly nine clock pulses again.

Top module: `scl_pulse_filter`

## Requirements
- R1: While reset is asserted and after its release, with the input low, `scl_clean_o` is 0 and `glitch_cnt_o` is 0.
- R2: An input high pulse that lasts N sample cycles, with N at or above the effective threshold T, gives exactly one output high pulse of N-T+1 cycles.
- R3: The output rises on the (T+1)-th clock edge after the first edge that samples the input high. With the edge that first samples it counted as edge 0, that is edge T+1.
- R4: The output falls on the second clock edge after the first edge that samples the input low.
- R5: An input high pulse shorter than T cycles leaves the output low throughout, and `glitch_cnt_o` increases by one.
- R6: `glitch_cnt_o` saturates at its all-ones value and then holds.
- R7: A threshold value of 0 acts as a threshold of 1.
- R8: A high pulse longer than the width counter's range keeps the output high until the input falls.
- R9: A burst of nine valid pulses with one phantom short pulse mixed in yields exactly nine output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_raw_i | input | 1 | Asynchronous SCL level from the controller |
| min_width_i | input | CNT_W | Minimum high width in sample cycles (0 acts as 1) |
| scl_clean_o | output | 1 | Filtered clock to the downstream device |
| glitch_cnt_o | output | GLITCH_W | Saturating count of rejected pulses |

## Verification
Directed pulses set exactly at, one below and one above the threshold show whether the comparison boundary is inclusive. Random widths and thresholds test the output width and rise latency against the N-T+1 and T+1 formulas. A threshold of 0, a pulse far longer than the counter range, a nine-pulse burst with a phantom inserted, and a long run of glitches separate the zero-threshold, counter-saturation, pulse-count and glitch-saturation behaviours.

// File: rtl/scl_filt_pkg.sv
package scl_filt_pkg;
  localparam int unsigned DEF_CNT_W     = 8;
  localparam int unsigned DEF_GLITCH_W  = 8;
  localparam int unsigned DEF_SYNC_STG  = 2;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = scl_filt_pkg::DEF_SYNC_STG
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_comb chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scl_width_qual.sv
module scl_width_qual #(
  parameter int unsigned CNT_W = scl_filt_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             clean_o,
  output logic             reject_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, thr_eff;
  logic             out_q, out_d, en;

  always_comb begin
    thr_eff  = (thr_i == '0) ? ONE : thr_i;
    cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE;
    cnt_d    = lvl_i ? cnt_inc : '0;
    out_d    = lvl_i && (out_q || (cnt_d >= thr_eff));
    en       = lvl_i || (cnt_q != '0) || out_q;
    reject_o = !lvl_i && (cnt_q != '0) && !out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clean_o = out_q;

  AST_OUT_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> $past(lvl_i)); // R2
  AST_OUT_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q && !lvl_i) |=> !out_q); // R4
  AST_RISE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> (cnt_q >= $past(thr_eff))); // R3
  AST_HOLD_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q && lvl_i) |=> out_q); // R8
endmodule

// File: rtl/scl_glitch_cnt.sv
module scl_glitch_cnt #(
  parameter int unsigned GLITCH_W = scl_filt_pkg::DEF_GLITCH_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_i,
  output logic [GLITCH_W-1:0] count_o
);
  localparam logic [GLITCH_W-1:0] GMAX = {GLITCH_W{1'b1}};

  logic [GLITCH_W-1:0] cnt_q, cnt_d;
  logic                en;

  always_comb begin
    en    = inc_i && (cnt_q != GMAX);
    cnt_d = cnt_q + {{(GLITCH_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (en)  cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  AST_GLITCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R5
  AST_GLITCH_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == GMAX) |=> (cnt_q == GMAX)); // R6
endmodule

// File: rtl/scl_pulse_filter.sv
module scl_pulse_filter #(
  parameter int unsigned CNT_W    = scl_filt_pkg::DEF_CNT_W,
  parameter int unsigned GLITCH_W = scl_filt_pkg::DEF_GLITCH_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_raw_i,
  input  logic [CNT_W-1:0]    min_width_i,
  output logic                scl_clean_o,
  output logic [GLITCH_W-1:0] glitch_cnt_o
);
  logic scl_sync, clean, reject;

  scl_sync #(.STAGES(scl_filt_pkg::DEF_SYNC_STG)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (scl_raw_i),
    .q_o    (scl_sync)
  );

  scl_width_qual #(.CNT_W(CNT_W)) i_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (scl_sync),
    .thr_i    (min_width_i),
    .clean_o  (clean),
    .reject_o (reject)
  );

  scl_glitch_cnt #(.GLITCH_W(GLITCH_W)) i_gcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (reject),
    .count_o (glitch_cnt_o)
  );

  assign scl_clean_o = clean;

  AST_GLITCH_WHEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glitch_cnt_o != $past(glitch_cnt_o)) |-> !$past(clean)); // R5
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!scl_clean_o && (glitch_cnt_o == '0))); // R1
endmodule

// File: tb/test_scl_pulse_filter.sv
module test_scl_pulse_filter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int GW = 4;
  localparam int GMAX = (1 << GW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          raw = 1'b0;
  logic [CW-1:0] thr = 8'd4;
  logic          clean;
  logic [GW-1:0] gcnt;

  int checks = 0;
  int fails = 0;
  int exp_glitch = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_pulse_filter #(.CNT_W(CW), .GLITCH_W(GW)) i_scl_pulse_filter (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_raw_i    (raw),
    .min_width_i  (thr),
    .scl_clean_o  (clean),
    .glitch_cnt_o (gcnt)
  );

  function automatic int eff_thr(int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int exp_high(int n, int t);
    return (n >= eff_thr(t)) ? n - eff_thr(t) + 1 : 0;
  endfunction

  function automatic int exp_first(int n, int t);
    return (n >= eff_thr(t)) ? eff_thr(t) + 1 : -1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one high pulse of n cycles then l low cycles (l >= 3), starting at a negedge.
  task automatic pulse(int n, int l, string req, output int rises);
    int hi = 0;
    int first = -1;
    bit prev = 1'b0;
    int t = int'(thr);
    rises = 0;
    raw = 1'b1;
    for (int k = 0; k < n + l; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (clean) begin
        hi++;
        if (first < 0) first = k;
      end
      if (clean && !prev) rises++;
      prev = clean;
      if (k == n - 1) raw = 1'b0;
    end
    if (n < eff_thr(t)) exp_glitch++;
    check({req, " width"}, hi, exp_high(n, t));
    check({req, " latency"}, first, exp_first(n, t));
    check({req, " glitches"}, int'(gcnt), (exp_glitch > GMAX) ? GMAX : exp_glitch);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 clean in reset", int'(clean), 0);
    check("R1 count in reset", int'(gcnt), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 clean after reset", int'(clean), 0);
    check("R1 count after reset", int'(gcnt), 0);

    // Boundary around threshold: R2 R3 R4 R5
    thr = 8'd6;
    pulse(6, 4, "R2 at threshold", r);
    pulse(5, 4, "R5 one below", r);
    check("R5 no output pulse", r, 0);
    pulse(7, 4, "R3 one above", r);
    pulse(1, 4, "R5 single sample", r);

    // Zero threshold: R7
    thr = 8'd0;
    pulse(1, 4, "R7 zero threshold", r);
    check("R7 one pulse", r, 1);

    // Counter range overflow: R8
    thr = 8'd10;
    pulse(300, 4, "R8 long pulse", r);
    check("R8 single pulse", r, 1);

    // Byte plus ACK with one phantom: R9
    begin
      int total = 0;
      thr = 8'd8;
      for (int i = 0; i < 10; i++) begin
        pulse((i == 4) ? 2 : 20, 12, "R9 burst", r);
        total += r;
      end
      check("R9 nine pulses", total, 9);
    end

    // Random widths and thresholds: R2 R3 R4 R5
    for (int i = 0; i < 200; i++) begin
      thr = CW'($urandom_range(1, 20));
      pulse(int'($urandom_range(1, 40)), int'($urandom_range(3, 10)), "R2 random", r);
    end

    // Glitch saturation: R6
    thr = 8'd12;
    for (int i = 0; i < GMAX + 3; i++) pulse(3, 3, "R6 saturate", r);
    check("R6 saturated value", int'(gcnt), GMAX);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule